// File: doc/BRIEF.md
# Phase-Frequency Comparator with Reference Divider and Lock Flag

This block is the digital heart of one channel of a frequency synthesizer loop. A programmable reference divider, clocked by the oscillator input, produces a one-cycle reference tick once every R oscillator cycles. A three-state phase-frequency comparator weighs each reference tick against the feedback tick that arrives from the loop divider. Its output is a pair of pump commands, raise or lower, that drive an external charge pump. Between corrections the pump is parked in high impedance.

Configuration inputs select the phase sense to match the slope of the oscillator being tuned, force the pump into high impedance, and pass a pump-current selection straight through. A power-down input idles the comparator and the lock logic. The reference divider keeps running until the companion channel is powered down as well. A lock flag rises after a run of narrow corrections. While locked it dips low for the length of every correction pulse, and it falls on the first wide correction.

Top module: `pfd_lock_top`

## Requirements
- R1: With R = `ref_div` of at least 3, `fr_mon` is high for exactly one cycle in every R cycles. The counter starts from zero at reset, so the first tick is seen R cycles after reset is released.
- R2: A `ref_div` value of 0, 1 or 2 is treated as 3.
- R3: The reference divider halts, with `fr_mon` held low, only while both `pwr_dn` and `pwr_dn_other` are high. With just one of them high it keeps ticking.
- R4: The comparator has three states: idle, raise and lower. A reference tick from idle enters raise, and a feedback tick from idle enters lower. The opposite tick returns it to idle. Ticks arriving together from idle leave it idle. The state is registered, so a tick seen at one clock edge shows on the pump outputs after that edge.
- R5: With `pol_pos` high, the raise state drives `pump_up` and the lower state drives `pump_dn`. With `pol_pos` low the two are swapped.
- R6: While `force_hiz` is high, `pump_hiz` is high and both `pump_up` and `pump_dn` are low. The comparator keeps working underneath.
- R7: While `pwr_dn` is high, the comparator is forced to idle, `pump_up` and `pump_dn` are low, `pump_hiz` is high, `fp_mon` is low, and the lock state is cleared.
- R8: `pump_hiz` is high whenever the comparator is idle.
- R9: `cur_sel` follows `cur_hi` in the same cycle.
- R10: A comparison ends each time the comparator returns to idle on a tick. Its width is the number of cycles the comparator spent out of idle. After 4 consecutive comparisons whose width is below LOCK_WIDTH (default 3), the lock state is set. The first comparison of width LOCK_WIDTH or more clears the lock state and restarts the run.
- R11: `lock` is the lock state masked low during every cycle in which the comparator is out of idle.
- R12: After reset: `pump_up`, `pump_dn`, `lock` and `fr_mon` are low, and `pump_hiz` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_div | input | 15 | Reference division ratio R |
| fb_pulse | input | 1 | One-cycle feedback tick from the loop divider |
| pol_pos | input | 1 | Phase sense: high for a positive tuning slope |
| force_hiz | input | 1 | Force the pump into high impedance |
| cur_hi | input | 1 | Pump current selection (high current when 1) |
| pwr_dn | input | 1 | Power-down for this channel |
| pwr_dn_other | input | 1 | Power-down state of the companion channel |
| pump_up | output | 1 | Pump raise command |
| pump_dn | output | 1 | Pump lower command |
| pump_hiz | output | 1 | Pump high-impedance enable |
| cur_sel | output | 1 | Current selection forwarded to the pump |
| lock | output | 1 | Lock flag, low during each correction |
| fr_mon | output | 1 | Reference tick, for monitoring |
| fp_mon | output | 1 | Feedback tick, gated by power-down |

## Verification
The comparator is first driven with feedback ticks that land in the same cycle as the reference tick. This isolates zero-width comparisons and the climb to lock. Feedback ticks lagging by one cycle give narrow raise pulses, which show the lock flag dipping while it stays locked. Lags of four cycles give wide pulses and separate a correct unlock from a stuck lock. A free-running feedback tick at a different period sweeps both leading and lagging cases, and it repeats under inverted phase sense so that swapped and unswapped pump commands can be told apart. Ratios below three, a single-channel power-down and a two-channel power-down distinguish the clamp and the halting rule of the divider.

// File: rtl/pfd_pkg.sv
// Package: shared constants and the comparator state type.
// Assumes: nothing beyond standard SystemVerilog.
package pfd_pkg;
    // smallest legal reference ratio; smaller requests are raised to this
    localparam int unsigned REF_MIN = 3;

    // three-state phase-frequency comparator
    typedef enum logic [1:0] {
        PFD_IDLE  = 2'd0,
        PFD_RAISE = 2'd1,
        PFD_LOWER = 2'd2
    } pfd_state_e;
endpackage

// File: rtl/ref_divider.sv
// Module: programmable reference divider.
// Emits a registered one-cycle tick every R clocks, with R clamped to at
// least REF_MIN. Halts only when both channels are powered down.
// Assumes: ref_div may change at any time; the counter then wraps at the new limit.
module ref_divider #(
    parameter int unsigned RW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ref_div,
    input  logic          pd_self,
    input  logic          pd_other,
    output logic          tick
);
    import pfd_pkg::*;

    localparam logic [RW-1:0] R_FLOOR = RW'(REF_MIN);

    logic [RW-1:0] cnt_q;
    logic          tick_q;
    logic [RW-1:0] r_eff;
    logic [RW-1:0] wrap_at;
    logic          halted;

    // clamp the ratio and derive the wrap value
    always_comb begin
        r_eff   = (ref_div < R_FLOOR) ? R_FLOOR : ref_div;
        wrap_at = r_eff - RW'(1);
        halted  = pd_self && pd_other;
    end

    // count oscillator cycles and fire the tick on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (halted) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q >= wrap_at) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + RW'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // R1: the ratio is at least three, so a tick never lasts two cycles
    a_r1_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);

    // R3: a halted divider produces no tick
    a_r3_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_self && pd_other) |=> !tick_q);
endmodule

// File: rtl/pfd_core.sv
// Module: three-state phase-frequency comparator and pump output stage.
// A reference tick moves idle to raise, a feedback tick moves idle to lower,
// and the opposite tick returns to idle (one finished comparison).
// Assumes: fr_i and fp_i are one-cycle ticks synchronous to clk.
module pfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic fr_i,
    input  logic fp_i,
    input  logic pwr_dn,
    input  logic pol_pos,
    input  logic force_hiz,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_hiz,
    output logic active,
    output logic cmp_done
);
    import pfd_pkg::*;

    pfd_state_e state_q, state_d;
    logic       raise, lower, gate;

    // next-state and completion decode
    always_comb begin
        state_d  = state_q;
        cmp_done = 1'b0;
        if (pwr_dn) begin
            state_d = PFD_IDLE;
        end else begin
            unique case (state_q)
                PFD_IDLE: begin
                    if (fr_i && fp_i) cmp_done = 1'b1;
                    else if (fr_i)    state_d  = PFD_RAISE;
                    else if (fp_i)    state_d  = PFD_LOWER;
                end
                PFD_RAISE: begin
                    if (fp_i) begin
                        cmp_done = 1'b1;
                        state_d  = PFD_IDLE;
                    end
                end
                PFD_LOWER: begin
                    if (fr_i) begin
                        cmp_done = 1'b1;
                        state_d  = PFD_IDLE;
                    end
                end
                default: state_d = PFD_IDLE;
            endcase
        end
    end

    // hold the comparator state
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PFD_IDLE;
        else        state_q <= state_d;
    end

    // map the state onto pump commands with polarity and gating
    always_comb begin
        raise    = (state_q == PFD_RAISE);
        lower    = (state_q == PFD_LOWER);
        gate     = pwr_dn || force_hiz;
        pump_up  = !gate && (pol_pos ? raise : lower);
        pump_dn  = !gate && (pol_pos ? lower : raise);
        pump_hiz = gate || (state_q == PFD_IDLE);
        active   = (state_q != PFD_IDLE);
    end

    // R6: forced high impedance silences both commands
    a_r6_force_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        force_hiz |-> (pump_hiz && !pump_up && !pump_dn));

    // R7: power-down idles the comparator on the next cycle
    a_r7_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (state_q == PFD_IDLE));

    // R4: a finished comparison always lands in idle
    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_done |=> (state_q == PFD_IDLE));

    // R4: the two pump commands are never on together
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));
endmodule

// File: rtl/lock_detector.sv
// Module: lock qualifier. Measures each comparison's width in cycles and
// sets lock after LOCK_COUNT narrow comparisons in a row; one wide
// comparison clears it. The output is masked during each correction.
// Assumes: cmp_done is a one-cycle strobe from the comparator.
module lock_detector #(
    parameter int unsigned LOCK_WIDTH = 3,
    parameter int unsigned LOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic cmp_done,
    input  logic pwr_dn,
    output logic lock_o
);
    localparam int unsigned WW = $clog2(LOCK_WIDTH + 2);
    localparam int unsigned GW = $clog2(LOCK_COUNT + 1);
    localparam logic [WW-1:0] W_SAT = WW'(LOCK_WIDTH);
    localparam logic [GW-1:0] G_TOP = GW'(LOCK_COUNT);

    logic [WW-1:0] wcnt_q;
    logic [GW-1:0] good_q;
    logic          lock_q;
    logic [WW-1:0] width;
    logic          narrow;

    // width of the comparison that ends this cycle
    always_comb begin
        width  = wcnt_q + WW'(active);
        narrow = (width < W_SAT);
    end

    // width counter: counts active cycles, saturating, cleared per comparison
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn)       wcnt_q <= '0;
        else if (cmp_done)          wcnt_q <= '0;
        else if (active && wcnt_q < W_SAT) wcnt_q <= wcnt_q + WW'(1);
    end

    // run counter and lock state
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            good_q <= '0;
            lock_q <= 1'b0;
        end else if (cmp_done) begin
            if (narrow) begin
                if (good_q < G_TOP) good_q <= good_q + GW'(1);
                if (good_q + GW'(1) >= G_TOP) lock_q <= 1'b1;
            end else begin
                good_q <= '0;
                lock_q <= 1'b0;
            end
        end
    end

    assign lock_o = lock_q && !active;

    // R10: lock is only ever set by a finished comparison
    a_r10_rise_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(cmp_done));

    // R7: power-down clears the lock state
    a_r7_pd_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !lock_q);

    // R11: the flag is low while a correction is in progress
    a_r11_mask: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !lock_o);
endmodule

// File: rtl/pfd_lock_top.sv
// Module: one synthesizer channel's reference divider, phase-frequency
// comparator and lock flag.
// Assumes: fb_pulse is a one-cycle tick synchronous to clk; all
// configuration inputs are synchronous to clk.
module pfd_lock_top #(
    parameter int unsigned RW         = 15,
    parameter int unsigned LOCK_WIDTH = 3,
    parameter int unsigned LOCK_COUNT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ref_div,
    input  logic          fb_pulse,
    input  logic          pol_pos,
    input  logic          force_hiz,
    input  logic          cur_hi,
    input  logic          pwr_dn,
    input  logic          pwr_dn_other,
    output logic          pump_up,
    output logic          pump_dn,
    output logic          pump_hiz,
    output logic          cur_sel,
    output logic          lock,
    output logic          fr_mon,
    output logic          fp_mon
);
    logic fr_tick;
    logic cmp_active;
    logic cmp_done;

    ref_divider #(.RW(RW)) u_refdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_div  (ref_div),
        .pd_self  (pwr_dn),
        .pd_other (pwr_dn_other),
        .tick     (fr_tick)
    );

    pfd_core u_pfd (
        .clk       (clk),
        .rst_n     (rst_n),
        .fr_i      (fr_tick),
        .fp_i      (fb_pulse),
        .pwr_dn    (pwr_dn),
        .pol_pos   (pol_pos),
        .force_hiz (force_hiz),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn),
        .pump_hiz  (pump_hiz),
        .active    (cmp_active),
        .cmp_done  (cmp_done)
    );

    lock_detector #(.LOCK_WIDTH(LOCK_WIDTH), .LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (cmp_active),
        .cmp_done (cmp_done),
        .pwr_dn   (pwr_dn),
        .lock_o   (lock)
    );

    // monitor taps and the forwarded current selection
    always_comb begin
        fr_mon  = fr_tick;
        fp_mon  = fb_pulse && !pwr_dn;
        cur_sel = cur_hi;
    end

    // R8: an idle comparator always parks the pump
    a_r8_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_up && !pump_dn && !force_hiz && !pwr_dn && !cmp_active) |-> pump_hiz);
endmodule

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;
    localparam int LW = 3;
    localparam int LC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] ref_div = 15'd5;
    logic        fb_pulse = 1'b0;
    logic        pol_pos = 1'b1;
    logic        force_hiz = 1'b0;
    logic        cur_hi = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        pwr_dn_other = 1'b0;
    logic        pump_up, pump_dn, pump_hiz, cur_sel, lock, fr_mon, fp_mon;

    always #4 clk = ~clk;

    pfd_lock_top dut (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_pulse(fb_pulse),
        .pol_pos(pol_pos), .force_hiz(force_hiz), .cur_hi(cur_hi),
        .pwr_dn(pwr_dn), .pwr_dn_other(pwr_dn_other),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
        .cur_sel(cur_sel), .lock(lock), .fr_mon(fr_mon), .fp_mon(fp_mon)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string ph = "R12";

    // behavioural reference model (state: 0 idle, 1 raise, 2 lower)
    int m_cnt, m_st, m_w, m_g, reff;
    bit m_fr, m_lock;
    always @(posedge clk) begin
        int  o_st, width;
        bit  o_fr, u, d, act;
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_fr = 0; m_st = 0; m_w = 0; m_g = 0; m_lock = 0;
        end else begin
            o_fr = m_fr; o_st = m_st; act = (o_st != 0);
            reff = (ref_div < 3) ? 3 : int'(ref_div);
            if (pwr_dn && pwr_dn_other) begin m_cnt = 0; m_fr = 0; end
            else if (m_cnt >= reff - 1) begin m_cnt = 0; m_fr = 1; end
            else begin m_cnt++; m_fr = 0; end
            if (pwr_dn) begin
                m_st = 0; m_w = 0; m_g = 0; m_lock = 0;
            end else begin
                u = (o_st == 1) || o_fr;
                d = (o_st == 2) || fb_pulse;
                if (u && d) begin
                    m_st = 0; width = m_w + int'(act); m_w = 0;
                    if (width < LW) begin
                        m_g++;
                        if (m_g >= LC) begin m_g = LC; m_lock = 1; end
                    end else begin m_g = 0; m_lock = 0; end
                end else begin
                    m_st = u ? 1 : (d ? 2 : 0);
                    if (act) m_w++;
                end
            end
        end
    end

    task automatic chk(string req, string nm, logic act_v, logic exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0b expected %0b at cycle %0d",
                     req, ph, nm, act_v, exp_v, cyc);
        end
    endtask

    // compare every output against the model at the falling edge
    task automatic compare();
        bit gate, r, l, e_up, e_dn;
        gate = pwr_dn || force_hiz;
        r = (m_st == 1); l = (m_st == 2);
        e_up = !gate && (pol_pos ? r : l);
        e_dn = !gate && (pol_pos ? l : r);
        chk("R4/R5", "pump_up", pump_up, e_up);
        chk("R4/R5", "pump_dn", pump_dn, e_dn);
        chk("R6/R8", "pump_hiz", pump_hiz, gate || (m_st == 0));
        chk("R9", "cur_sel", cur_sel, cur_hi);
        chk("R10/R11", "lock", lock, m_lock && (m_st == 0));
        chk("R1", "fr_mon", fr_mon, m_fr);
        chk("R7", "fp_mon", fp_mon, fb_pulse && !pwr_dn);
    endtask

    // feedback generator: 0 none, 1 lag k after reference, 2 free period
    int fmode = 0, klag = 0, fper = 7, cd = -1, fcnt = 0;
    int fr_seen = 0, glitch_bad = 0, lock_seen = 0;
    int last_fr = -1, fr_gap = 0;

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            if (fr_mon) begin
                fr_seen++;
                if (last_fr >= 0) fr_gap = cyc - last_fr;
                last_fr = cyc;
            end
            if ((pump_up || pump_dn) && lock) glitch_bad++;
            if (lock) lock_seen++;
            if (fmode == 1) begin
                if (m_fr) cd = klag;
                fb_pulse = (cd == 0);
                if (cd >= 0) cd--;
            end else if (fmode == 2) begin
                fcnt++;
                fb_pulse = (fcnt >= fper);
                if (fcnt >= fper) fcnt = 0;
            end else fb_pulse = 1'b0;
        end
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12", "pump_up", pump_up, 1'b0);
        chk("R12", "pump_dn", pump_dn, 1'b0);
        chk("R12", "pump_hiz", pump_hiz, 1'b1);
        chk("R12", "lock", lock, 1'b0);
        chk("R12", "fr_mon", fr_mon, 1'b0);

        // R10: aligned feedback, zero-width comparisons -> lock
        ph = "R10 aligned"; fmode = 1; klag = 0;
        step(60);
        chk("R10", "lock after aligned run", lock, 1'b1);

        // R11: one-cycle lag keeps lock, flag dips during each pulse
        ph = "R11 lag1"; klag = 1; glitch_bad = 0; lock_seen = 0;
        step(60);
        chk("R11", "no lock while pumping", glitch_bad == 0, 1'b1);
        chk("R11", "lock still seen", lock_seen > 10, 1'b1);

        // R10: wide comparisons drop lock
        ph = "R10 lag4"; klag = 4;
        step(40);
        chk("R10", "unlock on wide pulses", lock, 1'b0);

        // R4: free-running feedback at a different period, both senses
        ph = "R4 free"; fmode = 2; fper = 7;
        step(120);
        ph = "R5 inverted"; pol_pos = 1'b0;
        step(120);
        pol_pos = 1'b1;

        // R6 forced high impedance, R9 current pass-through
        ph = "R6 forced"; force_hiz = 1'b1; cur_hi = 1'b1;
        step(60);
        force_hiz = 1'b0;
        ph = "R9 current"; step(20); cur_hi = 1'b0; step(5);

        // R2: small ratios clamp to three
        ph = "R2 clamp"; fmode = 1; klag = 0; ref_div = 15'd1;
        step(20);
        chk("R2", "period with R=1", fr_gap, 3);
        ref_div = 15'd0; step(20);
        chk("R2", "period with R=0", fr_gap, 3);
        ref_div = 15'd9; step(40);
        chk("R1", "period with R=9", fr_gap, 9);

        // R3/R7: one channel down -> divider runs, comparator idle
        ph = "R7 pd self"; fmode = 2; fper = 5; pwr_dn = 1'b1; fr_seen = 0;
        step(45);
        chk("R3", "divider runs with one channel down", fr_seen >= 4, 1'b1);
        chk("R7", "hiz in power-down", pump_hiz, 1'b1);
        ph = "R3 pd both"; pwr_dn_other = 1'b1; step(2); fr_seen = 0;
        step(40);
        chk("R3", "divider halted", fr_seen, 0);
        pwr_dn = 1'b0; pwr_dn_other = 1'b0;
        ph = "R4 resume"; fmode = 1; klag = 2; ref_div = 15'd5;
        step(80);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule